// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is the character-level core of one asynchronous serial channel. It turns parallel bytes into serial frames and rebuilds bytes from the serial input. A 7-bit line control word selects the character length (5 to 8 bits), the parity (odd, even, or forced to a constant), one or two stop bits, and a break condition. All bit timing comes from a 16x oversampling enable pulse that a baud generator outside the block supplies.

Transmit data is offered with a valid/ready handshake. Received characters appear on a holding output together with a data-ready flag and parity and framing error flags. A single-cycle read strobe acknowledges the character and clears all three flags. The line idles high. A frame is a start bit of 0, then the data bits with the LSB first, then the parity bit if enabled, then one or two stop bits of 1.

Top module: `uart_frame_core`

## Requirements
- R1: After reset the serial output is 1, `tx_ready_o` is 1, and `rx_ready_o`, `parity_err_o` and `frame_err_o` are 0.
- R2: A frame accepted on the handshake is sent as a 0 start bit, then `line_ctrl_i[1:0]`+5 data bits with the LSB first, and each bit lasts 16 oversample ticks.
- R3: With `line_ctrl_i[3]`=1 and `line_ctrl_i[5]`=0, a parity bit follows the data. It gives odd parity when `line_ctrl_i[4]`=0 and even parity when it is 1, counted over the active data bits only.
- R4: With `line_ctrl_i[3]`=1 and `line_ctrl_i[5]`=1, the parity bit is a constant: 1 when `line_ctrl_i[4]`=0, and 0 when it is 1. The same rule applies on transmit and on receive.
- R5: `line_ctrl_i[2]`=1 sends two stop bits, and 0 sends one. `tx_ready_o` returns to 1 only after the last stop bit.
- R6: While `line_ctrl_i[6]` (break) is 1, the serial output is 0 in the same cycle and `tx_ready_o` is 0. A frame in progress is abandoned, and after break is cleared the line is 1 until a new byte is accepted.
- R7: The receiver samples each bit at the middle of its 16 ticks. At the first stop bit it stores the character right-aligned and zero-filled in `rx_data_o` and sets `rx_ready_o`.
- R8: A start bit that is no longer 0 at its midpoint is rejected, and no character is stored.
- R9: A received parity bit that differs from the value given by R3/R4 sets `parity_err_o` together with `rx_ready_o`.
- R10: A first stop bit received as 0 sets `frame_err_o` together with `rx_ready_o`.
- R11: A pulse on `rx_read_i` clears `rx_ready_o`, `parity_err_o` and `frame_err_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversample enable, 16 per bit |
| line_ctrl_i | input | 7 | [1:0] length-5, [2] two stop, [3] parity on, [4] even/force-0, [5] force parity, [6] break |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| rx_read_i | input | 1 | Acknowledge received character |
| rx_data_o | output | 8 | Received character |
| rx_ready_o | output | 1 | Character available |
| parity_err_o | output | 1 | Parity mismatch on held character |
| frame_err_o | output | 1 | Stop bit 0 on held character |

## Verification
Transmit frames are captured with several settings: 8 bits with no parity, 7 bits with even parity, 5 bits with odd parity and two stops, and both forced parity values. These show whether the parity bit is computed over the masked data or is a constant, and whether the stop count sets the ready timing. On the receive side, frames with correct and inverted parity, a zero stop bit, a 5-bit character and a short glitch separate parity errors, framing errors, alignment and false-start rejection. A break applied in the middle of a frame checks that the line drops at once and that transmission restarts only with a fresh byte.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  typedef struct packed {
    logic       brk;
    logic       force_par;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len;
  } line_cfg_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} frame_st_e;

  function automatic logic [3:0] char_bits(line_cfg_t c);
    return 4'd5 + {2'b00, c.len};
  endfunction

  function automatic logic [7:0] char_mask(line_cfg_t c);
    return 8'hff >> (4'd8 - char_bits(c));
  endfunction

  function automatic logic par_bit(logic [7:0] d, line_cfg_t c);
    if (c.force_par) return !c.even;
    return c.even ? ^(d & char_mask(c)) : ~^(d & char_mask(c));
  endfunction
endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_frame_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  line_cfg_t         cfg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  frame_st_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        bit_idx_q;
  logic [DATA_W-1:0] sh_q;
  line_cfg_t         cfg_q;
  logic              par_q, stop2_q, line_q;

  assign ready_o = (state_q == ST_IDLE) && !cfg_i.brk;
  assign txd_o   = !cfg_i.brk && line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; bit_idx_q <= '0; sh_q <= '0;
      cfg_q <= '0; par_q <= 1'b0; stop2_q <= 1'b0; line_q <= 1'b1;
    end else if (cfg_i.brk) begin
      state_q <= ST_IDLE; cnt_q <= '0; line_q <= 1'b1;
    end else if (state_q == ST_IDLE) begin
      if (valid_i) begin
        sh_q <= data_i; cfg_q <= cfg_i; par_q <= par_bit(data_i, cfg_i);
        state_q <= ST_START; cnt_q <= '0; bit_idx_q <= '0; line_q <= 1'b0;
      end
    end else if (tick_i) begin
      if (cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: begin state_q <= ST_DATA; line_q <= sh_q[0]; end
          ST_DATA: begin
            if (bit_idx_q == char_bits(cfg_q) - 4'd1) begin
              if (cfg_q.par_en) begin state_q <= ST_PAR; line_q <= par_q; end
              else begin state_q <= ST_STOP; line_q <= 1'b1; stop2_q <= 1'b0; end
            end else begin
              bit_idx_q <= bit_idx_q + 4'd1;
              sh_q      <= sh_q >> 1;
              line_q    <= sh_q[1];
            end
          end
          ST_PAR: begin state_q <= ST_STOP; line_q <= 1'b1; stop2_q <= 1'b0; end
          ST_STOP: begin
            if (cfg_q.two_stop && !stop2_q) stop2_q <= 1'b1;
            else state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_BREAK_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.brk |=> state_q == ST_IDLE); // R6
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (cfg_i.brk || !txd_o)); // R2
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> bit_idx_q < char_bits(cfg_q)); // R2
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_frame_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  line_cfg_t         cfg_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(TICKS_PER_BIT / 2 - 1);

  frame_st_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        bit_idx_q;
  logic [DATA_W-1:0] sh_q, aligned;
  line_cfg_t         cfg_q;
  logic              perr_pend_q, sync1_q, rxd_s;
  logic              done;

  assign aligned = sh_q >> (4'd8 - char_bits(cfg_q));
  assign done    = (state_q == ST_STOP) && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1; rxd_s <= 1'b1;
    end else begin
      sync1_q <= rxd_i; rxd_s <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; bit_idx_q <= '0; sh_q <= '0;
      cfg_q <= '0; perr_pend_q <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (!rxd_s) begin
          state_q <= ST_START; cnt_q <= '0; cfg_q <= cfg_i;
        end
        ST_START: begin
          if (cnt_q == MID) begin
            cnt_q <= '0; bit_idx_q <= '0; perr_pend_q <= 1'b0;
            state_q <= rxd_s ? ST_IDLE : ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
            if (bit_idx_q == char_bits(cfg_q) - 4'd1)
              state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else bit_idx_q <= bit_idx_q + 4'd1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0; state_q <= ST_STOP;
            perr_pend_q <= rxd_s != par_bit(aligned, cfg_q);
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == LAST) begin cnt_q <= '0; state_q <= ST_IDLE; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0; rdy_o <= 1'b0; perr_o <= 1'b0; ferr_o <= 1'b0;
    end else if (done) begin
      data_o <= aligned; rdy_o <= 1'b1; perr_o <= perr_pend_q; ferr_o <= !rxd_s;
    end else if (rd_i) begin
      rdy_o <= 1'b0; perr_o <= 1'b0; ferr_o <= 1'b0;
    end
  end

  AST_RDY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rdy_o); // R7
  AST_FALSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == MID && rxd_s) |=> state_q == ST_IDLE); // R8
  AST_ERR_WITH_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o || ferr_o) |-> rdy_o); // R9
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done) |=> (!rdy_o && !perr_o && !ferr_o)); // R11
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core
  import uart_frame_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic [6:0]        line_ctrl_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              rx_read_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  line_cfg_t cfg;
  assign cfg = line_cfg_t'(line_ctrl_i);

  uart_tx_engine #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .cfg_i(cfg),
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o), .txd_o(txd_o)
  );

  uart_rx_engine #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .cfg_i(cfg),
    .rxd_i(rxd_i), .rd_i(rx_read_i), .data_o(rx_data_o), .rdy_o(rx_ready_o),
    .perr_o(parity_err_o), .ferr_o(frame_err_o)
  );

  AST_BREAK_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.brk |-> !tx_ready_o && !txd_o); // R6
endmodule

// File: tb/tb_uart_frame_core.sv
module tb_uart_frame_core;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [6:0] cfg = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic       tx_ready, txd, rx_ready, perr, ferr;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= !tick;

  uart_frame_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .line_ctrl_i(cfg),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .txd_o(txd),
    .rxd_i(rxd), .rx_read_i(rd), .rx_data_o(rx_data), .rx_ready_o(rx_ready),
    .parity_err_o(perr), .frame_err_o(ferr)
  );

  function automatic logic [6:0] mk(int len, bit two, bit pen, bit ev, bit frc, bit brk);
    return {brk, frc, ev, pen, two, 2'(len - 5)};
  endfunction

  function automatic bit exp_par(logic [7:0] d, int len, bit ev, bit frc);
    logic [7:0] m = d & (8'hff >> (8 - len));
    if (frc) return !ev;
    return ev ? ^m : ~^m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic tx_frame(logic [7:0] d, int len, bit two, bit pen, bit ev, bit frc, string req);
    bit bad = 0;
    @(negedge clk);
    cfg = mk(len, two, pen, ev, frc, 0); tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    wait_ticks(8);
    if (txd !== 1'b0) bad = 1;
    for (int i = 0; i < len; i++) begin
      wait_ticks(16);
      if (txd !== d[i]) bad = 1;
    end
    chk(!bad, {req, " data bits"}, d, d);
    if (pen) begin
      wait_ticks(16);
      chk(txd === exp_par(d, len, ev, frc), {req, " parity bit"}, txd, exp_par(d, len, ev, frc));
    end
    wait_ticks(16);
    chk(txd === 1'b1 && tx_ready === 1'b0, "R5 first stop", {txd, tx_ready}, 2'b10);
    if (two) begin
      wait_ticks(16);
      chk(txd === 1'b1 && tx_ready === 1'b0, "R5 second stop", {txd, tx_ready}, 2'b10);
    end
    wait_ticks(16);
    chk(tx_ready === 1'b1 && txd === 1'b1, "R5 ready after stop", {txd, tx_ready}, 2'b11);
  endtask

  task automatic drive_bit(logic b);
    rxd = b;
    wait_ticks(16);
  endtask

  task automatic rx_frame(logic [7:0] d, int len, bit pen, bit ev, bit frc, logic pbit,
                          logic stopv, bit eperr, bit eferr, string req);
    logic [7:0] expd = d & (8'hff >> (8 - len));
    cfg = mk(len, 0, pen, ev, frc, 0);
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) drive_bit(d[i]);
    if (pen) drive_bit(pbit);
    drive_bit(stopv);
    drive_bit(1'b1);
    chk(rx_ready === 1'b1 && rx_data === expd, {req, " R7 data"}, rx_data, expd);
    chk(perr === eperr && ferr === eferr, {req, " error flags"}, {perr, ferr}, {eperr, eferr});
    rd = 1;
    @(negedge clk);
    rd = 0;
    chk(!rx_ready && !perr && !ferr, "R11 read clears", {rx_ready, perr, ferr}, 0);
  endtask

  task automatic t_reset;
    chk(txd === 1'b1 && tx_ready === 1'b1, "R1 tx idle", {txd, tx_ready}, 2'b11);
    chk(!rx_ready && !perr && !ferr, "R1 rx flags", {rx_ready, perr, ferr}, 0);
  endtask

  task automatic t_tx;
    tx_frame(8'hA5, 8, 0, 0, 0, 0, "R2 8N1");
    tx_frame(8'hD3, 7, 0, 1, 1, 0, "R3 even 7");
    tx_frame(8'hF6, 5, 1, 1, 0, 0, "R3 odd 5 two-stop");
    tx_frame(8'h00, 8, 0, 1, 0, 1, "R4 forced one");
    tx_frame(8'h01, 6, 0, 1, 1, 1, "R4 forced zero");
  endtask

  task automatic t_break;
    @(negedge clk);
    cfg = mk(8, 0, 0, 0, 0, 0); tx_data = 8'hFF; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    wait_ticks(40);
    chk(txd === 1'b1, "R6 mid-frame high bit", txd, 1);
    cfg = mk(8, 0, 0, 0, 0, 1);
    #1;
    chk(txd === 1'b0 && tx_ready === 1'b0, "R6 break immediate", {txd, tx_ready}, 0);
    wait_ticks(200);
    chk(txd === 1'b0, "R6 break held", txd, 0);
    cfg = mk(8, 0, 0, 0, 0, 0);
    #1;
    chk(txd === 1'b1 && tx_ready === 1'b1, "R6 release idle", {txd, tx_ready}, 2'b11);
    wait_ticks(40);
    chk(txd === 1'b1, "R6 no resumed frame", txd, 1);
    tx_frame(8'h3C, 8, 0, 0, 0, 0, "R6 fresh frame");
  endtask

  task automatic t_rx;
    rx_frame(8'h3C, 8, 0, 0, 0, 0, 1'b1, 0, 0, "R7 8N1");
    rx_frame(8'h5A, 8, 1, 0, 0, exp_par(8'h5A, 8, 0, 0), 1'b1, 0, 0, "R3 rx odd ok");
    rx_frame(8'h5B, 7, 1, 1, 0, ~exp_par(8'h5B, 7, 1, 0), 1'b1, 1, 0, "R9 rx even bad");
    rx_frame(8'h12, 8, 1, 1, 1, 1'b1, 1'b1, 1, 0, "R9 forced zero got one");
    rx_frame(8'h12, 8, 1, 0, 1, 1'b1, 1'b1, 0, 0, "R4 forced one ok");
    rx_frame(8'h81, 8, 0, 0, 0, 0, 1'b0, 0, 1, "R10 stop zero");
    rx_frame(8'hFF, 5, 0, 0, 0, 0, 1'b1, 0, 0, "R7 5-bit zero fill");
  endtask

  task automatic t_false_start;
    cfg = mk(8, 0, 0, 0, 0, 0);
    rxd = 0;
    wait_ticks(4);
    rxd = 1;
    wait_ticks(200);
    chk(rx_ready === 1'b0, "R8 glitch rejected", rx_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx();
    t_break();
    t_rx();
    t_false_start();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule